// File: doc/BRIEF.md
# Dual I/O serial flash read controller

This block sits on the host side of a serial flash and turns a simple read request into a dual-I/O fast read on the flash pins. A request carries a 24-bit start address, a byte count and a flag that asks to keep continuous mode. The engine lowers chip select and sends the read opcode on one line. It then sends the address and a mode byte two bits per serial clock, releases both data lines, and collects bytes two bits per clock. Each byte is handed out on a valid/ready stream. Chip select stays low until the last requested byte has arrived.

When the request asks to keep continuous mode, the mode byte tells the flash to expect the next access without an opcode. The engine remembers this, so its next access starts straight at the address phase and saves eight clocks. An exit request sends a sixteen-clock mode-reset sequence, which returns both sides to normal command operation. The serial clock is the system clock divided by an even ratio. Outputs change on the falling serial edge and inputs are sampled on the rising edge. The idle level of the serial clock is a parameter (SPI mode 0 or mode 3).

The states are GAP, IDLE, CMD, ADDR, MODE, DATA and EXIT. Reset enters GAP, and GAP moves to IDLE after CS_GAP system clocks. IDLE moves to EXIT on an exit request. On an accepted request with a non-zero count, IDLE moves to CMD, or to ADDR when continuous mode is active. CMD moves to ADDR after 8 serial clocks, ADDR to MODE after 12, and MODE to DATA after 4. DATA moves to GAP on the falling edge after the last byte. EXIT moves to GAP after 16 serial clocks. Each of these transitions takes place on a falling-edge tick.

Top module: `dual_read_engine`

## Requirements
- R1: During and right after reset, `cs_n` is 1, `sclk` sits at IDLE_HIGH, `io_oe` is 2'b00, `out_valid` is 0 and `cont_active` is 0.
- R2: An access that is not in continuous mode starts with the opcode 8'hBB. The opcode is sent MSB first on `io_out[0]`, one bit per serial clock, over 8 clocks, with `io_oe` = 2'b01.
- R3: The address then goes out over 12 serial clocks with `io_oe` = 2'b11. Each clock carries an odd bit on `io_out[1]` and the even bit below it on `io_out[0]`, starting with A23/A22.
- R4: The mode byte follows over 4 clocks in the same two-bit format. Bits [5:4] are 2'b10 when `req_keep` is 1 and 2'b00 otherwise; all other mode bits are 0.
- R5: `io_oe` returns to 2'b00 on the falling edge that ends the mode phase, and it stays 2'b00 until `cs_n` rises. Data is sampled on rising edges, MSB first, with bit 7 on `io_in[1]` and bit 6 on `io_in[0]`. Bytes come out in ascending address order.
- R6: After a read, `cont_active` equals the `req_keep` of that read. While it is 1, the next access sends no opcode and begins with the address phase.
- R7: `exit_req` in IDLE runs 16 serial clocks with `io_out[0]` = 1, `io_oe` = 2'b01 and `io_out[1]` released. It then clears `cont_active`, so the next read sends the opcode again.
- R8: `cs_n` stays low for exactly `req_len` bytes of data clocks. It rises on the falling edge after the last data clock. A request with `req_len` = 0 is accepted without asserting `cs_n`. While `cs_n` is high, `sclk` sits at IDLE_HIGH and `io_oe` is 2'b00.
- R9: Between accesses, and after reset, `cs_n` stays high for at least CS_GAP system clocks. `req_ready` is 1 only while `cs_n` is high.
- R10: One serial clock period is CLK_DIV system clocks. While a line is driven, `io_out` changes only together with a falling `sclk`.
- R11: When `out_valid` is 1 and `out_ready` is 0, `sclk` halts during the data phase and `out_data` holds, so no byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | 24 | Start address |
| req_len | input | LEN_W | Number of bytes to read |
| req_keep | input | 1 | Ask the flash to stay in continuous mode |
| exit_req | input | 1 | Send the mode-reset sequence |
| out_valid | output | 1 | Read byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Read byte |
| cont_active | output | 1 | Continuous mode is in force |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock |
| io_out | output | 2 | Values driven on the two data lines |
| io_oe | output | 2 | Per-line output enable |
| io_in | input | 2 | Values read from the two data lines |

## Verification
A behavioural flash in the bench decodes the pins and serves bytes that depend on the address. The reads are ordered so that each keep/drop combination of continuous mode occurs: opcode then keep, no opcode then keep, no opcode then drop, and opcode again. This shows whether the engine tracks the mode on each side. Addresses near the top of the space show whether the two-bit split and the byte ordering hold. A consumer that accepts only every third cycle separates a stalled clock from lost data. A fully blocked consumer, an exit sequence and a zero-length request cover the halt, the mode reset and the no-access case.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

    typedef enum logic [2:0] {
        ST_GAP,
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_MODE,
        ST_DATA,
        ST_EXIT
    } dfr_state_e;

    localparam logic [7:0] OPC_DUAL_READ = 8'hBB;
    localparam int ADDR_W    = 24;
    localparam int CMD_CLKS  = 8;
    localparam int ADDR_CLKS = ADDR_W / 2;
    localparam int MODE_CLKS = 4;
    localparam int EXIT_CLKS = 16;

endpackage

// File: rtl/dfr_sclk_timer.sv
module dfr_sclk_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic run,
    output logic phase,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = run && (cnt == CW'(HALF - 1));
    assign rise_tick = wrap && !phase;
    assign fall_tick = wrap && phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (!active) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (run) begin
            if (wrap) begin
                cnt   <= '0;
                phase <= !phase;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dfr_rx_pair.sv
module dfr_rx_pair (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       sample,
    input  logic [1:0] pins,
    output logic       done,
    output logic [7:0] word
);
    logic [5:0] hist;
    logic [1:0] pcnt;

    assign done = sample && (pcnt == 2'd3);
    assign word = {hist, pins};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
            pcnt <= '0;
        end else if (clear) begin
            pcnt <= '0;
        end else if (sample) begin
            hist <= {hist[3:0], pins};
            pcnt <= pcnt + 2'd1;
        end
    end
endmodule

// File: rtl/dual_read_engine.sv
module dual_read_engine
    import dfr_pkg::*;
#(
    parameter int CLK_DIV   = 4,
    parameter int CS_GAP    = 3,
    parameter int LEN_W     = 16,
    parameter bit IDLE_HIGH = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [23:0]       req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_keep,
    input  logic              exit_req,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              cont_active,
    output logic              cs_n,
    output logic              sclk,
    output logic [1:0]        io_out,
    output logic [1:0]        io_oe,
    input  logic [1:0]        io_in
);
    localparam int GW = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
    localparam int SW = ADDR_W + 8;

    dfr_state_e        state_q, state_d;
    logic [GW-1:0]     gap_q;
    logic [4:0]        bit_q;
    logic [SW-1:0]     tx_q;
    logic [7:0]        cmd_q;
    logic [LEN_W-1:0]  remain_q;
    logic              keep_q, cont_q;
    logic              out_valid_q;
    logic [7:0]        out_data_q;

    logic active, stall, run, phase, rise_tick, fall_tick, start;
    logic rx_done;
    logic [7:0] rx_word;

    assign active = (state_q == ST_CMD) || (state_q == ST_ADDR) || (state_q == ST_MODE)
                 || (state_q == ST_DATA) || (state_q == ST_EXIT);
    assign stall  = (state_q == ST_DATA) && out_valid_q && !out_ready;
    assign run    = active && !stall;
    assign start  = (state_q == ST_IDLE) && !exit_req && req_valid && (req_len != '0);

    dfr_sclk_timer #(.DIV(CLK_DIV)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .run       (run),
        .phase     (phase),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    dfr_rx_pair u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state_q != ST_DATA),
        .sample (rise_tick && (state_q == ST_DATA)),
        .pins   (io_in),
        .done   (rx_done),
        .word   (rx_word)
    );

    // next-state logic: every phase change happens on a falling-edge tick
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GAP:  if (gap_q == GW'(CS_GAP - 1)) state_d = ST_IDLE;
            ST_IDLE: begin
                if (exit_req)   state_d = ST_EXIT;
                else if (start) state_d = cont_q ? ST_ADDR : ST_CMD;
            end
            ST_CMD:  if (fall_tick && bit_q == 5'(CMD_CLKS))  state_d = ST_ADDR;
            ST_ADDR: if (fall_tick && bit_q == 5'(ADDR_CLKS)) state_d = ST_MODE;
            ST_MODE: if (fall_tick && bit_q == 5'(MODE_CLKS)) state_d = ST_DATA;
            ST_DATA: if (fall_tick && remain_q == '0)         state_d = ST_GAP;
            ST_EXIT: if (fall_tick && bit_q == 5'(EXIT_CLKS)) state_d = ST_GAP;
            default: state_d = ST_GAP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_GAP;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q       <= '0;
            bit_q       <= '0;
            tx_q        <= '0;
            cmd_q       <= '0;
            remain_q    <= '0;
            keep_q      <= 1'b0;
            cont_q      <= 1'b0;
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
        end else begin
            gap_q <= (state_q == ST_GAP) ? gap_q + 1'b1 : '0;
            if (state_d != state_q) bit_q <= '0;
            else if (rise_tick)     bit_q <= bit_q + 5'd1;

            if (start) begin
                tx_q     <= {req_addr, 2'b00, (req_keep ? 2'b10 : 2'b00), 4'b0000};
                cmd_q    <= OPC_DUAL_READ;
                remain_q <= req_len;
                keep_q   <= req_keep;
            end
            if (fall_tick && state_q == ST_CMD) cmd_q <= {cmd_q[6:0], 1'b0};
            if (fall_tick && (state_q == ST_ADDR || state_q == ST_MODE))
                tx_q <= {tx_q[SW-3:0], 2'b00};
            if (state_q == ST_MODE && state_d == ST_DATA) cont_q <= keep_q;
            if (state_q == ST_EXIT && state_d == ST_GAP)  cont_q <= 1'b0;

            if (rx_done) begin
                out_data_q  <= rx_word;
                out_valid_q <= 1'b1;
                remain_q    <= remain_q - 1'b1;
            end else if (out_ready) begin
                out_valid_q <= 1'b0;
            end
        end
    end

    // outputs decoded from the state register
    always_comb begin
        cs_n   = !active;
        sclk   = active ? phase : IDLE_HIGH;
        io_out = 2'b00;
        io_oe  = 2'b00;
        unique case (state_q)
            ST_CMD: begin
                io_out = {1'b0, cmd_q[7]};
                io_oe  = 2'b01;
            end
            ST_ADDR, ST_MODE: begin
                io_out = tx_q[SW-1:SW-2];
                io_oe  = 2'b11;
            end
            ST_EXIT: begin
                io_out = 2'b01;
                io_oe  = 2'b01;
            end
            ST_GAP, ST_IDLE, ST_DATA: ;
            default: ;
        endcase
    end

    assign req_ready   = (state_q == ST_IDLE) && !exit_req;
    assign out_valid   = out_valid_q;
    assign out_data    = out_data_q;
    assign cont_active = cont_q;
endmodule

// File: rtl/dfr_checker.sv
module dfr_checker #(
    parameter int CS_GAP    = 3,
    parameter bit IDLE_HIGH = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sclk,
    input logic [1:0] io_out,
    input logic [1:0] io_oe,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       req_ready
);
    localparam int HW = $clog2(CS_GAP + 1);
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             hi_cnt <= '0;
        else if (!cs_n)                         hi_cnt <= '0;
        else if (hi_cnt != HW'(CS_GAP))         hi_cnt <= hi_cnt + 1'b1;
    end

    // R8: bus parked while deselected
    a_r8_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sclk == IDLE_HIGH) && (io_oe == 2'b00));

    // R9: minimum deselect time
    a_r9_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> hi_cnt >= HW'(CS_GAP));

    // R9: requests only taken while deselected
    a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cs_n);

    // R10: driven lines move only with a falling serial clock
    a_r10_io_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && io_oe != 2'b00 && $past(io_oe) != 2'b00
         && io_out != $past(io_out)) |-> $fell(sclk));

    // R11: a byte held back by the consumer stays put
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

bind dual_read_engine dfr_checker #(
    .CS_GAP    (CS_GAP),
    .IDLE_HIGH (IDLE_HIGH)
) u_dfr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .io_out    (io_out),
    .io_oe     (io_oe),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .req_ready (req_ready)
);

// File: tb/test_dual_read_engine.sv
module test_dual_read_engine;
    localparam int CLK_DIV = 4;
    localparam int CS_GAP  = 3;
    localparam int LEN_W   = 16;
    localparam int NVEC    = 6;
    // {keep, slow consumer, length, address}
    localparam logic [33:0] VECS [NVEC] = '{
        {1'b0, 1'b0, 8'd3, 24'h000010},
        {1'b1, 1'b0, 8'd2, 24'hABCDEF},
        {1'b1, 1'b1, 8'd4, 24'h123456},
        {1'b0, 1'b0, 8'd1, 24'hFFFFFE},
        {1'b0, 1'b1, 8'd2, 24'h555555},
        {1'b1, 1'b0, 8'd5, 24'hFFFFFD}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, req_valid, req_ready, req_keep, exit_req;
    logic out_valid, out_ready, cont_active, cs_n, sclk;
    logic [23:0] req_addr;
    logic [LEN_W-1:0] req_len;
    logic [7:0] out_data;
    logic [1:0] io_out, io_oe, io_in;

    dual_read_engine #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .LEN_W(LEN_W)) i_dual_read_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_keep(req_keep), .exit_req(exit_req),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .cont_active(cont_active), .cs_n(cs_n), .sclk(sclk),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    int checks = 0, fails = 0;
    longint cyc = 0;
    always @(posedge clk) cyc++;

    function automatic logic [7:0] mem_at(logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[20:16], 3'b101};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural flash
    int rc = 0, m_base = 8, contention = 0, n_exit = 0, k_idx;
    logic m_cont = 1'b0, m_cmdsess = 1'b0, sess = 1'b0, ex_ok = 1'b0;
    logic [7:0] m_cmd, m_mode, b_val;
    logic [23:0] m_addr;
    logic [1:0] drv = 2'b00;
    longint r1 = 0, r2 = 0;
    int s_rc = 0;
    logic s_cmd = 1'b0, s_exit_ok = 1'b0;
    logic [7:0] s_cmdv = '0, s_mode = '0;
    logic [23:0] s_addr = '0;
    assign io_in = drv;

    always @(negedge cs_n) begin
        sess = 1'b1; rc = 0; m_cmdsess = !m_cont; m_base = m_cont ? 0 : 8;
        m_cmd = '0; m_addr = '0; m_mode = '0; ex_ok = 1'b1; drv = 2'b00;
    end

    always @(posedge sclk) if (cs_n === 1'b0) begin
        if (io_oe != 2'b01 || !io_out[0]) ex_ok = 1'b0;
        if (rc == 0) r1 = cyc;
        if (rc == 1) r2 = cyc;
        if (m_cmdsess && rc < 8)    m_cmd  = {m_cmd[6:0], io_out[0]};
        else if (rc < m_base + 12)  m_addr = {m_addr[21:0], io_out};
        else if (rc < m_base + 16)  m_mode = {m_mode[5:0], io_out};
        rc++;
    end

    always @(negedge sclk) begin
        #1;
        if (cs_n === 1'b0 && rc >= m_base + 16) begin
            k_idx = rc - m_base - 16;
            b_val = mem_at(m_addr + 24'(k_idx / 4));
            drv   = 2'(b_val >> (6 - 2 * (k_idx % 4)));
            if (io_oe != 2'b00) contention++;
        end
    end

    always @(posedge cs_n) if (sess) begin
        sess = 1'b0; s_rc = rc; s_cmd = m_cmdsess; s_cmdv = m_cmd;
        s_addr = m_addr; s_mode = m_mode;
        if (rc == 16) begin n_exit++; s_exit_ok = ex_ok; m_cont = 1'b0; end
        else m_cont = (m_mode[5:4] == 2'b10);
    end

    int hi_run = 0, min_gap = 1000000;
    always @(posedge clk) if (rst_n) begin
        if (cs_n) hi_run++;
        else begin
            if (hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
            hi_run = 0;
        end
    end

    task automatic issue(input logic [23:0] a, input int len, input logic keep);
        @(negedge clk);
        req_addr = a; req_len = LEN_W'(len); req_keep = keep; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic collect(input logic [23:0] a, input int len, input bit slow);
        int got = 0, ph = 0;
        while (got < len) begin
            @(negedge clk);
            ph++;
            out_ready = !slow || (ph % 3 == 0);
            if (out_valid && out_ready) begin
                chk("R5 data byte", out_data, mem_at(a + 24'(got)));
                got++;
            end
        end
        @(negedge clk);
        out_ready = 1'b1;
        while (!cs_n) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    logic [33:0] v;
    logic exp_cont = 1'b0;
    int  rc_hold;
    logic [7:0] held;

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0; req_keep = 1'b0;
        exit_req = 1'b0; out_ready = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 cs_n", cs_n, 1); chk("R1 sclk", sclk, 0); chk("R1 io_oe", io_oe, 0);
        chk("R1 out_valid", out_valid, 0); chk("R1 cont_active", cont_active, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 ready low after reset", req_ready, 0);
        chk("R1 cs_n after reset", cs_n, 1);

        for (int i = 0; i < NVEC; i++) begin
            v = VECS[i];
            issue(v[23:0], int'(v[31:24]), v[33]);
            collect(v[23:0], int'(v[31:24]), v[32]);
            chk("R6 opcode present", s_cmd, !exp_cont);
            if (!exp_cont) chk("R2 opcode", s_cmdv, 8'hBB);
            chk("R3 address", s_addr, v[23:0]);
            chk("R4 mode bits", s_mode, v[33] ? 8'h20 : 8'h00);
            chk("R8 clocks under cs", s_rc, (exp_cont ? 0 : 8) + 16 + 4 * int'(v[31:24]));
            chk("R6 cont_active", cont_active, v[33]);
            chk("R5 no contention", contention, 0);
            if (i == 0) chk("R10 sclk period", 32'(r2 - r1), CLK_DIV);
            exp_cont = v[33];
        end

        // R7: mode reset
        @(negedge clk); exit_req = 1'b1;
        while (cs_n) @(negedge clk);
        exit_req = 1'b0;
        while (!cs_n) @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R7 exit seen", n_exit, 1);
        chk("R7 exit clocks", s_rc, 16);
        chk("R7 exit line levels", s_exit_ok, 1);
        chk("R7 cont cleared", cont_active, 0);
        issue(24'h0A0B0C, 1, 1'b0);
        collect(24'h0A0B0C, 1, 1'b0);
        chk("R7 opcode after exit", s_cmd, 1);
        chk("R7 opcode value", s_cmdv, 8'hBB);

        // R11: consumer blocked
        out_ready = 1'b0;
        issue(24'h00A0A0, 3, 1'b0);
        out_ready = 1'b0;
        while (!out_valid) @(negedge clk);
        rc_hold = rc; held = out_data;
        chk("R9 ready low while selected", req_ready, 0);
        repeat (40) @(negedge clk);
        chk("R11 clock halted", rc, rc_hold);
        chk("R11 byte held", out_data, held);
        chk("R11 first byte", held, mem_at(24'h00A0A0));
        collect(24'h00A0A0, 3, 1'b0);
        chk("R5 no contention after stall", contention, 0);

        // R8: zero-length request
        rc_hold = int'(cyc);
        issue(24'h001234, 0, 1'b0);
        hi_run = hi_run;
        repeat (20) @(negedge clk);
        chk("R8 zero length no select", min_gap >= 0 && cs_n, 1);
        chk("R8 zero length ready", req_ready, 1);
        chk("R9 minimum gap", min_gap >= CS_GAP, 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule